// File: doc/BRIEF.md
# Single-Burst Read Slave

This block is the target side of a memory-mapped read port. A master issues a read command that carries a start word address and a beat count. The slave answers with that many data words from its own word array, one word per cycle. The words come from consecutive addresses, and the address wraps at the end of the array.

The slave serves only one burst at a time. When it accepts a command, it raises `waitrequest` on the next clock edge. It holds `waitrequest` high through every returned beat, including the last one. So a master that streams commands back to back is held off until the current burst has drained. A held command is taken in the first cycle in which `waitrequest` is low again.

The word array has a separate write port so that a test environment can load its contents. This port is not part of the read protocol.

Top module: `brs_slave`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) forces `waitrequest` and `readdatavalid` low from that edge onward, and it abandons any burst in progress.
- R2: While no burst is active, `waitrequest` is low, so a read presented in that cycle is accepted at the end of the same cycle.
- R3: `waitrequest` is high in the cycle that follows the acceptance cycle.
- R4: An accepted command with `burstcount` N (1 to MAX_BURST) produces exactly N cycles of `readdatavalid`. The first of these is the cycle after acceptance, and the N cycles are consecutive with no gaps.
- R5: Beat k (counted from 0) of a burst that starts at address A returns the word stored at address (A + k) modulo the array depth.
- R6: `readdatavalid` is never high while `waitrequest` is low. `waitrequest` falls in the cycle right after the last beat, and never earlier.
- R7: A read that is presented while `waitrequest` is high starts no burst and produces no beat of its own while the stall lasts.
- R8: When `load_we` is high at a clock edge, `load_data` is written to word `load_addr`. Later bursts return the new value.
- R9: A command held back to back behind a burst is accepted in the cycle right after that burst's last beat. Its first beat follows one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| address | input | ADDR_W | Start word address of a read command |
| read | input | 1 | Read command request |
| burstcount | input | CNT_W | Beats requested, 1 to MAX_BURST |
| waitrequest | output | 1 | High while a burst is in service; commands are refused |
| readdata | output | DATA_W | Returned data word |
| readdatavalid | output | 1 | `readdata` holds a beat this cycle |
| load_we | input | 1 | Array load strobe |
| load_addr | input | ADDR_W | Array load word address |
| load_data | input | DATA_W | Array load word |

## Verification
The assertions assume that `burstcount` lies between 1 and MAX_BURST whenever `read` is high. They also assume that a command stalled by `waitrequest` keeps its address and count until it is taken. The bench drives commands only from a task that picks counts in that range. The task leaves `read`, `address` and `burstcount` untouched until it has seen `waitrequest` low. Array loads happen only while no burst is running, so the expected words never change in the middle of a burst.

// File: rtl/brs_pkg.sv
package brs_pkg;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_BURST = 1'b1
    } brs_state_e;

    // Width of a counter able to hold the value max_val.
    function automatic int unsigned cnt_width(input int unsigned max_val);
        return $clog2(max_val + 1);
    endfunction

    // Control snapshot of the burst in service.
    typedef struct packed {
        brs_state_e state;
        logic       beat_q;
    } brs_ctl_t;

endpackage

// File: rtl/brs_store.sv
module brs_store #(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] words [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_word
        always_ff @(posedge clk) begin
            if (wr_en && (wr_addr == ADDR_W'(i))) begin
                words[i] <= wr_data;
            end
        end
    end

    assign rd_data = words[rd_addr];

endmodule

// File: rtl/brs_seq.sv
module brs_seq
    import brs_pkg::*;
#(
    parameter int unsigned ADDR_W    = 4,
    parameter int unsigned MAX_BURST = 8,
    parameter int unsigned CNT_W     = cnt_width(MAX_BURST)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_read,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [CNT_W-1:0]  cmd_count,
    output logic              stall,
    output logic              fetch_en,
    output logic [ADDR_W-1:0] fetch_addr,
    output logic              beat_valid
);
    brs_ctl_t          ctl;
    logic [CNT_W-1:0]  left_q;
    logic [ADDR_W-1:0] next_addr_q;
    logic              accept;
    logic              more;

    assign stall      = (ctl.state == ST_BURST);
    assign accept     = cmd_read && (ctl.state == ST_IDLE);
    assign more       = (ctl.state == ST_BURST) && (left_q != '0);
    assign fetch_en   = accept || more;
    assign fetch_addr = accept ? cmd_addr : next_addr_q;
    assign beat_valid = ctl.beat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl.state   <= ST_IDLE;
            ctl.beat_q  <= 1'b0;
            left_q      <= '0;
            next_addr_q <= '0;
        end else begin
            ctl.beat_q <= fetch_en;
            if (accept) begin
                ctl.state   <= ST_BURST;
                left_q      <= cmd_count - CNT_W'(1);
                next_addr_q <= cmd_addr + ADDR_W'(1);
            end else if (more) begin
                left_q      <= left_q - CNT_W'(1);
                next_addr_q <= next_addr_q + ADDR_W'(1);
            end else if (ctl.state == ST_BURST) begin
                ctl.state <= ST_IDLE;
            end
        end
    end

    AST_STALL_ON_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        (cmd_read && !stall) |=> stall);                                // R3

    AST_FIRST_BEAT_NEXT: assert property (@(posedge clk) disable iff (rst)
        (cmd_read && !stall) |=> beat_valid);                           // R4

    AST_NO_BEAT_UNSTALLED: assert property (@(posedge clk) disable iff (rst)
        beat_valid |-> stall);                                          // R6

    AST_RELEASE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
        $fell(stall) |-> ($past(beat_valid) && !beat_valid));           // R6

    AST_LEFT_BOUND: assert property (@(posedge clk) disable iff (rst)
        stall |-> (left_q < CNT_W'(MAX_BURST)));                        // R4

endmodule

// File: rtl/brs_slave.sv
module brs_slave
    import brs_pkg::*;
#(
    parameter int unsigned ADDR_W    = 4,
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned MAX_BURST = 8,
    parameter int unsigned CNT_W     = cnt_width(MAX_BURST)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] address,
    input  logic              read,
    input  logic [CNT_W-1:0]  burstcount,
    output logic              waitrequest,
    output logic [DATA_W-1:0] readdata,
    output logic              readdatavalid,
    input  logic              load_we,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic [DATA_W-1:0] load_data
);
    logic              fetch_en;
    logic [ADDR_W-1:0] fetch_addr;
    logic [DATA_W-1:0] fetch_word;
    logic [DATA_W-1:0] data_q;

    brs_seq #(
        .ADDR_W    (ADDR_W),
        .MAX_BURST (MAX_BURST),
        .CNT_W     (CNT_W)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .cmd_read   (read),
        .cmd_addr   (address),
        .cmd_count  (burstcount),
        .stall      (waitrequest),
        .fetch_en   (fetch_en),
        .fetch_addr (fetch_addr),
        .beat_valid (readdatavalid)
    );

    brs_store #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_store (
        .clk     (clk),
        .wr_en   (load_we),
        .wr_addr (load_addr),
        .wr_data (load_data),
        .rd_addr (fetch_addr),
        .rd_data (fetch_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
        end else if (fetch_en) begin
            data_q <= fetch_word;
        end
    end

    assign readdata = data_q;

    // Beat accounting checker: counts beats against the latched request.
    logic [CNT_W-1:0] chk_want;
    logic [CNT_W-1:0] chk_got;

    always_ff @(posedge clk) begin
        if (rst) begin
            chk_want <= '0;
            chk_got  <= '0;
        end else if (read && !waitrequest) begin
            chk_want <= burstcount;
            chk_got  <= '0;
        end else if (readdatavalid) begin
            chk_got <= chk_got + CNT_W'(1);
        end
    end

    AST_BEAT_COUNT: assert property (@(posedge clk) disable iff (rst)
        $fell(waitrequest) |-> (chk_got == chk_want));                  // R4

    AST_BEAT_WITHIN: assert property (@(posedge clk) disable iff (rst)
        readdatavalid |-> (chk_got < chk_want));                        // R4

    AST_STALL_HOLDS_CMD: assert property (@(posedge clk) disable iff (rst)
        (read && waitrequest) |=> (waitrequest || readdatavalid == 1'b0)); // R7

endmodule

// File: tb/brs_slave_tb.sv
module brs_slave_tb;
    localparam int unsigned ADDR_W = 4;
    localparam int unsigned DATA_W = 32;
    localparam int unsigned MAXB   = 8;
    localparam int unsigned CNT_W  = 4;
    localparam int unsigned DEPTH  = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [ADDR_W-1:0] address = '0;
    logic              read = 1'b0;
    logic [CNT_W-1:0]  burstcount = '0;
    logic              waitrequest;
    logic [DATA_W-1:0] readdata;
    logic              readdatavalid;
    logic              load_we = 1'b0;
    logic [ADDR_W-1:0] load_addr = '0;
    logic [DATA_W-1:0] load_data = '0;

    brs_slave #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MAX_BURST(MAXB), .CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst(rst), .address(address), .read(read), .burstcount(burstcount),
        .waitrequest(waitrequest), .readdata(readdata), .readdatavalid(readdatavalid),
        .load_we(load_we), .load_addr(load_addr), .load_data(load_data)
    );

    always #4 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 0;
    logic [DATA_W-1:0] model [DEPTH];
    logic [DATA_W-1:0] exp_data_q [$];
    int                exp_cyc_q  [$];
    int                last_beat_cyc = 0;
    bit                prev_rdv = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard on every beat (R4, R5, R6).
    always @(negedge clk) begin
        if (!rst) begin
            if (readdatavalid) begin
                if (exp_data_q.size() == 0) begin
                    check(0, "R4", "unexpected beat", 1, 0);
                end else begin
                    logic [DATA_W-1:0] ed;
                    int ec;
                    ed = exp_data_q.pop_front();
                    ec = exp_cyc_q.pop_front();
                    check(readdata == ed, "R5", "beat data", readdata, ed);
                    check(cyc == ec, "R4", "beat cycle", cyc, ec);
                    check(waitrequest == 1'b1, "R6", "stall during beat", waitrequest, 1);
                end
            end else if (prev_rdv) begin
                check(waitrequest == 1'b0, "R6", "release after last beat", waitrequest, 0);
            end
            prev_rdv = readdatavalid;
        end else begin
            prev_rdv = 0;
        end
    end

    task automatic preload(input int a, input logic [DATA_W-1:0] d);
        load_we = 1'b1; load_addr = ADDR_W'(a); load_data = d;
        @(negedge clk);
        load_we = 1'b0;
        model[a] = d;
    endtask

    // Driver: presents a command, holds it while stalled, pushes expectations.
    task automatic issue(input int a, input int n, input bit b2b);
        int stalls = 0;
        read = 1'b1; address = ADDR_W'(a); burstcount = CNT_W'(n);
        if (!b2b) check(waitrequest == 1'b0, "R2", "idle accepts", waitrequest, 0);
        while (waitrequest) begin
            @(negedge clk);
            stalls++;
        end
        if (b2b) check(cyc == last_beat_cyc + 1, "R9", "b2b accept cycle", cyc, last_beat_cyc + 1);
        for (int k = 0; k < n; k++) begin
            exp_data_q.push_back(model[(a + k) % DEPTH]);
            exp_cyc_q.push_back(cyc + 1 + k);
        end
        last_beat_cyc = cyc + n;
        @(negedge clk);
        check(waitrequest == 1'b1, "R3", "stall after accept", waitrequest, 1);
    endtask

    task automatic idle_until_drained();
        read = 1'b0;
        while (waitrequest || readdatavalid) @(negedge clk);
        @(negedge clk);
        check(exp_data_q.size() == 0, "R4", "all beats returned", exp_data_q.size(), 0);
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        // R8: load the array through the load port
        for (int i = 0; i < DEPTH; i++) preload(i, 32'hC0DE0000 + 32'(i * 7 + 3));
        check(waitrequest == 1'b0 && readdatavalid == 1'b0, "R1", "reset state",
              {waitrequest, readdatavalid}, 0);
        rst = 1'b0;
        @(negedge clk);

        // Single beat and maximum burst
        issue(2, 1, 0);
        idle_until_drained();
        issue(5, MAXB, 0);
        idle_until_drained();

        // R5: wrap at top of array
        issue(13, 6, 0);
        idle_until_drained();

        // R7/R9: back-to-back commands held against the stall
        issue(0, 3, 0);
        issue(9, 2, 1);
        issue(15, 4, 1);
        issue(7, 1, 1);
        idle_until_drained();

        // R8: overwrite one word and read it back
        preload(4, 32'hFEEDBEEF);
        issue(3, 3, 0);
        idle_until_drained();

        // R1: reset in the middle of a burst
        issue(1, MAXB, 0);
        read = 1'b0;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check(waitrequest == 1'b0, "R1", "stall cleared by reset", waitrequest, 0);
        check(readdatavalid == 1'b0, "R1", "valid cleared by reset", readdatavalid, 0);
        exp_data_q.delete();
        exp_cyc_q.delete();
        rst = 1'b0;
        repeat (3) @(negedge clk);
        check(readdatavalid == 1'b0, "R1", "no beats after reset", readdatavalid, 0);

        issue(10, 5, 0);
        idle_until_drained();

        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule